// File: doc/BRIEF.md
# Two-Port Burst Interconnect Arbiter

The arbiter lets two requesting ports share one downstream target port. Every port carries 32-bit words and uses the same small command set: a single access, or a four-word burst whose word addresses step up by four bytes. Port A is served on any cycle of the clock. Port B shares that clock but is sampled and answered only on cycles where the input `b_phase` is high, so it behaves like a half-rate port with no clock crossing. When both ports ask on the same free cycle, port A is served first. Once a port is granted, it keeps the grant until its last response word has been delivered.

On a requesting port, the words of a write burst may arrive with idle cycles between them. The arbiter gathers them into a four-word buffer. Only when all four are held does it issue them downstream as one unbroken burst. A read burst is sent downstream as four back-to-back beats. The returned words are buffered and then handed back, with port B's words waiting for its phase cycles.

Before any request goes downstream, its address is checked against a window set by parameters. For a burst, all four word addresses must lie inside the window. A request that misses the window never appears downstream and receives an error response.

The controller has five states:
- IDLE: waits for a request and makes the grant.
- GATHER: collects write-burst words.
- ISSUE: drives downstream beats.
- RDWAIT: waits for read data.
- REPLY: returns responses.

Its transitions are:
- grant-to-gather: IDLE→GATHER, for a write burst.
- grant-to-issue: IDLE→ISSUE, for an in-window single access or read burst.
- grant-to-reply: IDLE→REPLY, for a missed window.
- gather-done: GATHER→ISSUE, or GATHER→REPLY when the window was missed.
- write-issued: ISSUE→REPLY.
- read-issued: ISSUE→RDWAIT.
- data-complete: RDWAIT→REPLY.
- reply-done: REPLY→IDLE.

Top module: `dual_port_burst_arbiter`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transaction, no accept is asserted, both response codes are 2'b00 and the downstream command is idle; a later request completes normally.
- R2: A single write (command 2'b01, burst low) inside the window appears downstream as one beat carrying its address and data, and the requester receives one response of code 2'b01.
- R3: A single read (command 2'b10) inside the window returns the downstream data word to the requester with code 2'b01.
- R4: The four words of a write burst, presented with any number of idle cycles between them, are issued downstream at addresses base, base+4, base+8 and base+12, in order, with their data. The requester then receives four responses of code 2'b01.
- R5: A read burst issues four downstream read beats and returns four words to the requester, in address order, each with code 2'b01.
- R6: A downstream burst is never split: from its first beat to the beat flagged `m_last`, the command stays asserted. While `m_accept` is low, the command and address hold.
- R7: When both ports request while the arbiter is idle (with `b_phase` high), port A is accepted and port B waits.
- R8: While one port's transaction is in progress, the other port's request is not accepted until the last response word has been delivered.
- R9: `b_accept` and a nonzero `b_resp` occur only on cycles where `b_phase` is high.
- R10: A request whose address, or whose last burst word address, falls outside [WIN_BASE, WIN_BASE+WIN_SIZE) produces no downstream beat. It receives error code 2'b11: once for a single access, four times for a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_cmd | input | 2 | Port A command: 00 idle, 01 write, 10 read |
| a_addr | input | ADDR_W | Port A byte address |
| a_wdata | input | DATA_W | Port A write word |
| a_burst | input | 1 | Port A request is a four-word burst |
| a_accept | output | 1 | Port A command word taken this cycle |
| a_resp | output | 2 | Port A response: 00 none, 01 ok, 11 error |
| a_rdata | output | DATA_W | Port A read word |
| b_phase | input | 1 | Port B active-cycle indication |
| b_cmd | input | 2 | Port B command |
| b_addr | input | ADDR_W | Port B byte address |
| b_wdata | input | DATA_W | Port B write word |
| b_burst | input | 1 | Port B burst flag |
| b_accept | output | 1 | Port B command word taken this cycle |
| b_resp | output | 2 | Port B response code |
| b_rdata | output | DATA_W | Port B read word |
| m_cmd | output | 2 | Downstream command |
| m_addr | output | ADDR_W | Downstream byte address |
| m_wdata | output | DATA_W | Downstream write word |
| m_burst | output | 1 | Downstream beat belongs to a burst |
| m_last | output | 1 | Final beat of the downstream transfer |
| m_accept | input | 1 | Downstream beat taken |
| m_resp | input | 2 | Downstream read response code |
| m_rdata | input | DATA_W | Downstream read word |

## Verification
A wrong word counter or buffer index shows up at the downstream port within the same burst, as a misplaced address, misplaced data or a gap in the command. A wrong owner or state shows up at the requesters as an accept on the wrong port or a response outside a port B phase cycle, on the very cycle it occurs. A stuck controller shows as a response that never arrives, which is caught one transaction later. Window errors are seen as downstream traffic on a request that should have been refused.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RD   = 2'b10
    } arb_cmd_e;

    localparam logic [1:0] RSP_NONE = 2'b00;
    localparam logic [1:0] RSP_OK   = 2'b01;
    localparam logic [1:0] RSP_ERR  = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATHER,
        ST_ISSUE,
        ST_RDWAIT,
        ST_REPLY
    } arb_state_e;
endpackage

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio (
    input  logic enable,
    input  logic req_a,
    input  logic req_b,
    input  logic b_slot,
    output logic gnt_a,
    output logic gnt_b
);
    always_comb begin
        gnt_a = enable && req_a;
        gnt_b = enable && !req_a && req_b && b_slot;
    end
endmodule

// File: rtl/arb_addr_window.sv
module arb_addr_window #(
    parameter int              ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE = '0,
    parameter logic [ADDR_W-1:0] SIZE = '1,
    parameter int              SPAN   = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO_LIM = {1'b0, BASE};
    localparam logic [ADDR_W:0] HI_LIM = {1'b0, BASE} + {1'b0, SIZE};

    logic [ADDR_W:0] first_w;
    logic [ADDR_W:0] last_w;

    always_comb begin
        first_w = {1'b0, addr};
        last_w  = first_w + (burst ? (ADDR_W+1)'(SPAN) : '0);
        hit     = (first_w >= LO_LIM) && (last_w < HI_LIM);
    end
endmodule

// File: rtl/arb_burst_buf.sv
module arb_burst_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (we && widx == IDX_W'(g))
                slot[g] <= wdata;
        end
    end

    always_comb begin
        rdata_a = slot[ridx_a];
        rdata_b = slot[ridx_b];
    end
endmodule

// File: rtl/dual_port_burst_arbiter.sv
module dual_port_burst_arbiter
    import arb_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 32,
    parameter int                BURST_LEN = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE  = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        a_cmd,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    input  logic              a_burst,
    output logic              a_accept,
    output logic [1:0]        a_resp,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_phase,
    input  logic [1:0]        b_cmd,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    input  logic              b_burst,
    output logic              b_accept,
    output logic [1:0]        b_resp,
    output logic [DATA_W-1:0] b_rdata,
    output logic [1:0]        m_cmd,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_burst,
    output logic              m_last,
    input  logic              m_accept,
    input  logic [1:0]        m_resp,
    input  logic [DATA_W-1:0] m_rdata
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int IDX_W      = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam int CNT_W      = $clog2(BURST_LEN + 1);
    localparam int SPAN       = (BURST_LEN - 1) * BEAT_BYTES;

    arb_state_e state_q, state_d;

    logic              owner_q;      // 0: port A, 1: port B
    logic              is_wr_q;
    logic              burst_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  nb_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  iss_q;
    logic [CNT_W-1:0]  rx_q;

    // grant and new-request view
    logic              gnt_a, gnt_b, grant;
    logic              new_wr, new_burst, win_hit;
    logic [ADDR_W-1:0] new_addr;
    logic [DATA_W-1:0] new_wdata;

    arb_fixed_prio u_prio (
        .enable (state_q == ST_IDLE),
        .req_a  (a_cmd != CMD_IDLE),
        .req_b  (b_cmd != CMD_IDLE),
        .b_slot (b_phase),
        .gnt_a  (gnt_a),
        .gnt_b  (gnt_b)
    );

    always_comb begin
        grant     = gnt_a || gnt_b;
        new_wr    = gnt_a ? (a_cmd == CMD_WR) : (b_cmd == CMD_WR);
        new_burst = gnt_a ? a_burst : b_burst;
        new_addr  = gnt_a ? a_addr  : b_addr;
        new_wdata = gnt_a ? a_wdata : b_wdata;
    end

    arb_addr_window #(
        .ADDR_W (ADDR_W),
        .BASE   (WIN_BASE),
        .SIZE   (WIN_SIZE),
        .SPAN   (SPAN)
    ) u_win (
        .addr  (new_addr),
        .burst (new_burst),
        .hit   (win_hit)
    );

    // owner-side view
    logic              own_slot, own_is_wr;
    logic [DATA_W-1:0] own_wdata;
    logic              gather_take, reply_take, m_take, rx_take, iss_last;

    always_comb begin
        own_slot    = owner_q ? b_phase : 1'b1;
        own_is_wr   = owner_q ? (b_cmd == CMD_WR) : (a_cmd == CMD_WR);
        own_wdata   = owner_q ? b_wdata : a_wdata;
        gather_take = (state_q == ST_GATHER) && own_is_wr && own_slot;
        reply_take  = (state_q == ST_REPLY) && own_slot;
        m_take      = (state_q == ST_ISSUE) && m_accept;
        rx_take     = ((state_q == ST_ISSUE) || (state_q == ST_RDWAIT)) &&
                      !is_wr_q && (m_resp != RSP_NONE) && (rx_q < nb_q);
        iss_last    = (iss_q == nb_q - CNT_W'(1));
    end

    // burst buffer
    logic              buf_we;
    logic [IDX_W-1:0]  buf_widx;
    logic [DATA_W-1:0] buf_wdata, buf_iss, buf_rep;

    always_comb begin
        buf_we = ((state_q == ST_IDLE) && grant && new_wr) || gather_take || rx_take;
        unique case (state_q)
            ST_IDLE:   begin buf_widx = '0;              buf_wdata = new_wdata; end
            ST_GATHER: begin buf_widx = IDX_W'(cnt_q);   buf_wdata = own_wdata; end
            default:   begin buf_widx = IDX_W'(rx_q);    buf_wdata = m_rdata;   end
        endcase
    end

    arb_burst_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (BURST_LEN),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (buf_we),
        .widx    (buf_widx),
        .wdata   (buf_wdata),
        .ridx_a  (IDX_W'(iss_q)),
        .rdata_a (buf_iss),
        .ridx_b  (IDX_W'(cnt_q)),
        .rdata_b (buf_rep)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (grant) begin
                    if (new_wr && new_burst) state_d = ST_GATHER;  // grant-to-gather
                    else if (!win_hit)       state_d = ST_REPLY;   // grant-to-reply
                    else                     state_d = ST_ISSUE;   // grant-to-issue
                end
            end
            ST_GATHER: begin
                if (gather_take && cnt_q == CNT_W'(BURST_LEN - 1))
                    state_d = err_q ? ST_REPLY : ST_ISSUE;         // gather-done
            end
            ST_ISSUE: begin
                if (m_take && iss_last)
                    state_d = is_wr_q ? ST_REPLY : ST_RDWAIT;      // write-issued / read-issued
            end
            ST_RDWAIT: begin
                if (rx_q == nb_q) state_d = ST_REPLY;              // data-complete
            end
            ST_REPLY: begin
                if (reply_take && cnt_q == nb_q - CNT_W'(1))
                    state_d = ST_IDLE;                             // reply-done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transaction context and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= 1'b0;
            is_wr_q <= 1'b0;
            burst_q <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            nb_q    <= CNT_W'(1);
            cnt_q   <= '0;
            iss_q   <= '0;
            rx_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (grant) begin
                        owner_q <= gnt_b;
                        is_wr_q <= new_wr;
                        burst_q <= new_burst;
                        err_q   <= !win_hit;
                        addr_q  <= new_addr;
                        nb_q    <= new_burst ? CNT_W'(BURST_LEN) : CNT_W'(1);
                        cnt_q   <= (new_wr && new_burst) ? CNT_W'(1) : '0;
                        iss_q   <= '0;
                        rx_q    <= '0;
                    end
                end
                ST_GATHER: begin
                    if (gather_take)
                        cnt_q <= (cnt_q == CNT_W'(BURST_LEN - 1)) ? '0 : cnt_q + CNT_W'(1);
                end
                ST_ISSUE, ST_RDWAIT: begin
                    if (m_take) iss_q <= iss_q + CNT_W'(1);
                    if (rx_take) begin
                        rx_q <= rx_q + CNT_W'(1);
                        if (m_resp == RSP_ERR) err_q <= 1'b1;
                    end
                end
                ST_REPLY: begin
                    if (reply_take) cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    logic [1:0]        rep_code;
    logic [DATA_W-1:0] rep_word;

    always_comb begin
        rep_code = err_q ? RSP_ERR : RSP_OK;
        rep_word = (!is_wr_q && !err_q) ? buf_rep : '0;

        a_accept = gnt_a || (gather_take && !owner_q);
        b_accept = gnt_b || (gather_take && owner_q);

        a_resp   = RSP_NONE;
        a_rdata  = '0;
        b_resp   = RSP_NONE;
        b_rdata  = '0;
        if (state_q == ST_REPLY && !owner_q) begin
            a_resp  = rep_code;
            a_rdata = rep_word;
        end
        if (state_q == ST_REPLY && owner_q && b_phase) begin
            b_resp  = rep_code;
            b_rdata = rep_word;
        end

        m_cmd   = CMD_IDLE;
        m_burst = 1'b0;
        m_last  = 1'b0;
        if (state_q == ST_ISSUE) begin
            m_cmd   = is_wr_q ? CMD_WR : CMD_RD;
            m_burst = burst_q;
            m_last  = iss_last;
        end
        m_addr  = addr_q + ADDR_W'(iss_q) * ADDR_W'(BEAT_BYTES);
        m_wdata = (state_q == ST_ISSUE && is_wr_q) ? buf_iss : '0;
    end
endmodule

// File: rtl/dual_port_burst_arbiter_chk.sv
module dual_port_burst_arbiter_chk
    import arb_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0001_0000,
    parameter int                STEP     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input arb_state_e        state,
    input logic [1:0]        a_cmd,
    input logic              a_accept,
    input logic              b_accept,
    input logic              b_phase,
    input logic [1:0]        b_resp,
    input logic [1:0]        m_cmd,
    input logic [ADDR_W-1:0] m_addr,
    input logic              m_burst,
    input logic              m_last,
    input logic              m_accept
);
    localparam logic [ADDR_W:0] TOP = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

    assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_accept && b_accept));

    assert_a_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && a_cmd != 2'b00) |-> (a_accept && !b_accept));

    assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_GATHER) |-> (!a_accept && !b_accept));

    assert_b_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (b_accept || b_resp != 2'b00) |-> b_phase);

    assert_no_split_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != 2'b00 && m_burst && m_accept && !m_last)
            |=> (m_cmd == $past(m_cmd) && m_burst));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != 2'b00 && !m_accept) |=> ($stable(m_cmd) && $stable(m_addr)));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != 2'b00 && m_burst && m_accept && !m_last)
            |=> (m_addr == $past(m_addr) + ADDR_W'(STEP)));

    assert_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cmd != 2'b00) |-> ({1'b0, m_addr} >= {1'b0, WIN_BASE} && {1'b0, m_addr} < TOP));
endmodule

bind dual_port_burst_arbiter dual_port_burst_arbiter_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE),
    .STEP     (DATA_W / 8)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .a_cmd    (a_cmd),
    .a_accept (a_accept),
    .b_accept (b_accept),
    .b_phase  (b_phase),
    .b_resp   (b_resp),
    .m_cmd    (m_cmd),
    .m_addr   (m_addr),
    .m_burst  (m_burst),
    .m_last   (m_last),
    .m_accept (m_accept)
);

// File: tb/dual_port_burst_arbiter_tb.sv
module dual_port_burst_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  a_cmd = 2'b00;  logic [31:0] a_addr = '0, a_wdata = '0; logic a_burst = 1'b0;
    logic        a_accept;       logic [1:0]  a_resp;  logic [31:0] a_rdata;
    logic        b_phase;
    logic [1:0]  b_cmd = 2'b00;  logic [31:0] b_addr = '0, b_wdata = '0; logic b_burst = 1'b0;
    logic        b_accept;       logic [1:0]  b_resp;  logic [31:0] b_rdata;
    logic [1:0]  m_cmd;          logic [31:0] m_addr, m_wdata;
    logic        m_burst, m_last;
    logic        m_accept;       logic [1:0]  m_resp;  logic [31:0] m_rdata;

    int nchk = 0, nfail = 0;
    bit finished = 0;
    bit stall = 0;

    always #5 clk = ~clk;

    dual_port_burst_arbiter u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_cmd(a_cmd), .a_addr(a_addr), .a_wdata(a_wdata), .a_burst(a_burst),
        .a_accept(a_accept), .a_resp(a_resp), .a_rdata(a_rdata),
        .b_phase(b_phase),
        .b_cmd(b_cmd), .b_addr(b_addr), .b_wdata(b_wdata), .b_burst(b_burst),
        .b_accept(b_accept), .b_resp(b_resp), .b_rdata(b_rdata),
        .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata), .m_burst(m_burst),
        .m_last(m_last), .m_accept(m_accept), .m_resp(m_resp), .m_rdata(m_rdata)
    );

    // port B phase: high every other cycle
    initial begin
        b_phase = 1'b0;
        forever @(negedge clk) b_phase = ~b_phase;
    end

    // downstream target model and log
    logic [31:0] wlog_addr [64];
    logic [31:0] wlog_data [64];
    int wcnt = 0, rcnt = 0, split_cnt = 0;
    bit pend = 0, in_burst = 0;
    logic [31:0] pend_addr = '0;

    initial begin
        m_accept = 1'b1; m_resp = 2'b00; m_rdata = '0;
        forever begin
            @(negedge clk);
            m_resp   = pend ? 2'b01 : 2'b00;
            m_rdata  = pend ? (pend_addr ^ 32'h5A5A_0000) : 32'h0;
            m_accept = stall ? ~m_accept : 1'b1;
            pend      = (m_cmd == 2'b10) && m_accept;
            pend_addr = m_addr;
            if (m_cmd == 2'b01 && m_accept) begin
                if (wcnt < 64) begin
                    wlog_addr[wcnt] = m_addr;
                    wlog_data[wcnt] = m_wdata;
                end
                wcnt++;
            end
            if (m_cmd == 2'b10 && m_accept) rcnt++;
            if (in_burst && m_cmd == 2'b00) split_cnt++;
            if (m_cmd != 2'b00 && m_accept && m_burst) in_burst = !m_last;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // one transaction on port A (port=0) or B (port=1)
    task automatic txn(input bit port, input logic [1:0] cmd, input bit burst,
                       input logic [31:0] addr, input int gap,
                       output logic [3:0][1:0] rc, output logic [3:0][31:0] rd,
                       output int nresp, output time t_acc0, output time t_rsp_last);
        int nb = burst ? 4 : 1;
        int nbc = (cmd == 2'b01) ? nb : 1;
        rc = '0; rd = '0; nresp = 0; t_acc0 = 0; t_rsp_last = 0;
        @(negedge clk);
        for (int i = 0; i < nbc; i++) begin
            int guard = 0;
            if (!port) begin
                a_cmd = cmd; a_addr = addr + 4*i; a_wdata = addr + 4*i + 32'h1000_0000; a_burst = burst;
            end else begin
                b_cmd = cmd; b_addr = addr + 4*i; b_wdata = addr + 4*i + 32'h1000_0000; b_burst = burst;
            end
            #1;
            while (!(port ? b_accept : a_accept) && guard < 400) begin
                @(negedge clk); #1; guard++;
            end
            if (port) check(b_phase == 1'b1, "R9", "accept off-phase", 32'(b_phase), 32'd1);
            if (i == 0) t_acc0 = $time;
            @(negedge clk);
            if (!port) a_cmd = 2'b00; else b_cmd = 2'b00;
            if (i != nbc - 1) repeat (gap) @(negedge clk);
        end
        for (int k = 0; k < 400 && nresp < nb; k++) begin
            #1;
            if ((port ? b_resp : a_resp) != 2'b00) begin
                if (port) check(b_phase == 1'b1, "R9", "response off-phase", 32'(b_phase), 32'd1);
                rc[nresp] = port ? b_resp : a_resp;
                rd[nresp] = port ? b_rdata : a_rdata;
                nresp++;
                t_rsp_last = $time;
            end
            @(negedge clk);
        end
    endtask

    typedef struct packed {
        logic        port;
        logic [1:0]  cmd;
        logic        burst;
        logic [31:0] addr;
        logic [3:0]  gap;
        logic [1:0]  exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b0, 2'b01, 1'b0, 32'h0001_0010, 4'd0, 2'b01},
        '{1'b0, 2'b10, 1'b0, 32'h0001_0020, 4'd0, 2'b01},
        '{1'b1, 2'b01, 1'b0, 32'h0001_0100, 4'd0, 2'b01},
        '{1'b1, 2'b10, 1'b1, 32'h0001_0200, 4'd0, 2'b01},
        '{1'b0, 2'b01, 1'b1, 32'h0001_0300, 4'd2, 2'b01},
        '{1'b0, 2'b10, 1'b1, 32'h0001_0400, 4'd0, 2'b01},
        '{1'b0, 2'b01, 1'b0, 32'h0003_0000, 4'd0, 2'b11},
        '{1'b1, 2'b10, 1'b1, 32'h0001_FFF8, 4'd0, 2'b11},
        '{1'b0, 2'b01, 1'b1, 32'h0000_8000, 4'd1, 2'b11},
        '{1'b1, 2'b01, 1'b1, 32'h0001_1000, 4'd3, 2'b01}
    };

    // run one transaction and check it against the requirements
    task automatic run_check(input bit port, input logic [1:0] cmd, input bit burst,
                             input logic [31:0] addr, input int gap, input logic [1:0] exp);
        logic [3:0][1:0]  rc;
        logic [3:0][31:0] rd;
        int nresp, w0, r0, nb;
        time ta, tr;
        string tag;
        nb = burst ? 4 : 1;
        if (exp == 2'b11)               tag = "R10";
        else if (cmd == 2'b01 && !burst) tag = "R2";
        else if (cmd == 2'b10 && !burst) tag = "R3";
        else if (cmd == 2'b01)           tag = "R4";
        else                             tag = "R5";
        w0 = wcnt; r0 = rcnt;
        txn(port, cmd, burst, addr, gap, rc, rd, nresp, ta, tr);
        repeat (2) @(negedge clk);
        check(nresp == nb, tag, "response count", 32'(nresp), 32'(nb));
        for (int k = 0; k < nb; k++)
            check(rc[k] == exp, tag, "response code", 32'(rc[k]), 32'(exp));
        if (exp == 2'b11) begin
            check(wcnt == w0 && rcnt == r0, tag, "downstream beats on refused request",
                  32'(wcnt - w0 + rcnt - r0), 32'd0);
        end else if (cmd == 2'b10) begin
            check(rcnt - r0 == nb, tag, "downstream read beats", 32'(rcnt - r0), 32'(nb));
            for (int k = 0; k < nb; k++)
                check(rd[k] == ((addr + 4*k) ^ 32'h5A5A_0000), tag, "read word",
                      rd[k], (addr + 4*k) ^ 32'h5A5A_0000);
        end else begin
            check(wcnt - w0 == nb, tag, "downstream write beats", 32'(wcnt - w0), 32'(nb));
            for (int k = 0; k < nb; k++) begin
                check(wlog_addr[(w0+k)%64] == addr + 4*k, tag, "write address",
                      wlog_addr[(w0+k)%64], addr + 4*k);
                check(wlog_data[(w0+k)%64] == addr + 4*k + 32'h1000_0000, tag, "write data",
                      wlog_data[(w0+k)%64], addr + 4*k + 32'h1000_0000);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
        summary();
    end

    initial begin
        logic [3:0][1:0]  rc_a, rc_b;
        logic [3:0][31:0] rd_a, rd_b;
        int na, nbr, w0;
        time ta_a, tr_a, ta_b, tr_b;

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(a_accept == 0 && b_accept == 0, "R1", "accept after reset", 32'(a_accept | b_accept), 32'd0);
        check(a_resp == 0 && b_resp == 0, "R1", "response after reset", 32'({a_resp, b_resp}), 32'd0);
        check(m_cmd == 0, "R1", "downstream command after reset", 32'(m_cmd), 32'd0);

        // vector table
        for (int vi = 0; vi < 10; vi++)
            run_check(VECS[vi].port, VECS[vi].cmd, VECS[vi].burst, VECS[vi].addr,
                      int'(VECS[vi].gap), VECS[vi].exp);

        // R6: downstream stalls while bursts are issued
        stall = 1;
        run_check(1'b0, 2'b01, 1'b1, 32'h0001_2000, 1, 2'b01);
        run_check(1'b1, 2'b10, 1'b1, 32'h0001_2100, 0, 2'b01);
        stall = 0;
        check(split_cnt == 0, "R6", "idle cycles inside downstream bursts", 32'(split_cnt), 32'd0);

        // R7: simultaneous requests, phase high at the decision edge
        @(negedge clk);
        while (b_phase != 1'b0) @(negedge clk);
        fork
            txn(1'b0, 2'b10, 1'b0, 32'h0001_3000, 0, rc_a, rd_a, na, ta_a, tr_a);
            txn(1'b1, 2'b10, 1'b0, 32'h0001_3004, 0, rc_b, rd_b, nbr, ta_b, tr_b);
        join
        check(ta_a < ta_b, "R7", "port A accepted first (A time)", 32'(ta_a), 32'(ta_b));
        check(na == 1 && nbr == 1 && rc_b[0] == 2'b01, "R7", "both complete",
              32'(na + nbr), 32'd2);
        check(rd_b[0] == (32'h0001_3004 ^ 32'h5A5A_0000), "R7", "port B data after waiting",
              rd_b[0], 32'h0001_3004 ^ 32'h5A5A_0000);

        // R8: port A asks in the middle of a port B burst
        w0 = wcnt;
        fork
            txn(1'b1, 2'b01, 1'b1, 32'h0001_4000, 3, rc_b, rd_b, nbr, ta_b, tr_b);
            begin
                repeat (6) @(negedge clk);
                txn(1'b0, 2'b01, 1'b0, 32'h0001_5000, 0, rc_a, rd_a, na, ta_a, tr_a);
            end
        join
        check(ta_a > tr_b, "R8", "port A accepted after port B finished", 32'(ta_a), 32'(tr_b));
        check(wlog_addr[(w0+3)%64] == 32'h0001_400C && wlog_addr[(w0+4)%64] == 32'h0001_5000,
              "R8", "downstream order", wlog_addr[(w0+4)%64], 32'h0001_5000);
        check(nbr == 4 && na == 1, "R8", "response counts", 32'(nbr + na), 32'd5);

        // R1: reset in the middle of a gathered write burst
        @(negedge clk);
        a_cmd = 2'b01; a_addr = 32'h0001_6000; a_wdata = 32'h1234_5678; a_burst = 1'b1;
        @(negedge clk);
        a_cmd = 2'b00;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(a_resp == 0 && m_cmd == 0 && a_accept == 0, "R1", "idle after mid-burst reset",
              32'({a_resp, m_cmd, a_accept}), 32'd0);
        run_check(1'b0, 2'b10, 1'b0, 32'h0001_7000, 0, 2'b01);
        check(split_cnt == 0, "R6", "idle cycles inside downstream bursts (final)", 32'(split_cnt), 32'd0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule